// File: doc/BRIEF.md
# Mode-Selectable UART FIFO Controller

This block holds the transmit and receive buffers of a legacy-compatible UART, together with the logic that chooses how deep those buffers are. Software writes three small registers over a simple write-only register bus: a FIFO control register, a line control register and an enhanced-feature register. From a few bits of these registers the block picks one of four compatibility modes. It then sets the effective depth of both buffers to 1, 16 or 128 entries.

The depth-extension bit in the FIFO control register is guarded. A write can change it only while the latch bit of the line control register is set. The block reports the active mode and the two feature enables that belong to the deep-FIFO non-enhanced mode. Each buffer has a valid/ready push stream, a valid/ready pop stream, full and empty flags, and an overrun pulse.

On the push side, `*_in_ready` is high exactly when the buffer is not full, and it does not depend on a pop in the same cycle. A beat is taken when valid and ready are both high. A beat offered while ready is low is discarded, not held. On the pop side, `*_out_valid` is high whenever the buffer holds data, and `*_out_data` is the oldest entry. That entry is removed on a cycle with valid and ready both high.

Top module: `uart_fifo_mode_ctrl`

## Requirements
- R1: After reset the mode code is 0 (byte mode) and the depth is 1. Both buffers are empty with ready high, and both feature enables are low.
- R2: While bit 0 of the FIFO control register (address 0) is 0, the depth stays 1 and the mode stays 0. This holds whatever the extension bit and the enhanced bit hold.
- R3: With bit 0 = 1, the extension bit = 0 and the enhanced bit = 0, the mode code is 1 and the depth is 16. No input selects any other 16-entry variant.
- R4: With bit 0 = 1, the extension bit (bit 5 of address 0) = 1 and the enhanced bit = 0, the mode code is 2 and the depth is 128.
- R5: A write to address 0 updates bit 5 only while bit 7 of the line control register (address 1) is 1. Otherwise the stored bit 5 is kept, and bit 0 is still written.
- R6: With bit 0 = 1 and the enhanced bit (bit 4 of address 2) = 1, the mode code is 3 and the depth is 128, whatever bit 5 holds.
- R7: The flow-control enable and the sleep enable are high only in mode 2, and they are low whenever the enhanced bit is set.
- R8: Each buffer returns its data in push order. Ready is high exactly when the count is below the depth, and valid is high exactly when the count is non-zero.
- R9: The full flag is high when the count equals the depth. A beat offered while full is dropped, and the overrun output goes high in the following cycle, one cycle per dropped beat.
- R10: A register write that changes the depth empties both buffers, and they read empty in the cycle after the write. A write that keeps the depth leaves the contents intact.
- R11: The pointers wrap modulo the current depth, so the data order holds across the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 FIFO control, 1 line control, 2 enhanced feature |
| reg_wdata | input | 8 | Register write data |
| mode | output | 3 | 0 byte, 1 sixteen-deep, 2 deep non-enhanced, 3 enhanced |
| depth | output | 8 | Current effective depth |
| auto_flow_en | output | 1 | Automatic out-of-band flow control enable |
| sleep_en | output | 1 | Sleep enable |
| tx_in_valid | input | 1 | Transmit push valid |
| tx_in_ready | output | 1 | Transmit push ready |
| tx_in_data | input | 8 | Transmit push data |
| tx_out_valid | output | 1 | Transmit pop valid |
| tx_out_ready | input | 1 | Transmit pop ready |
| tx_out_data | output | 8 | Transmit oldest entry |
| tx_full | output | 1 | Transmit buffer full |
| tx_empty | output | 1 | Transmit buffer empty |
| tx_overrun | output | 1 | Transmit dropped-push pulse |
| rx_in_valid | input | 1 | Receive push valid |
| rx_in_ready | output | 1 | Receive push ready |
| rx_in_data | input | 8 | Receive push data |
| rx_out_valid | output | 1 | Receive pop valid |
| rx_out_ready | input | 1 | Receive pop ready |
| rx_out_data | output | 8 | Receive oldest entry |
| rx_full | output | 1 | Receive buffer full |
| rx_empty | output | 1 | Receive buffer empty |
| rx_overrun | output | 1 | Receive dropped-push pulse |

## Verification
A wrong mode latch shows on `mode` and `depth` in the first cycle after the register write, and that cycle is where the bench samples them. A pointer that wraps at the wrong limit does not show at once. It is revealed only when the buffer is filled to exactly the depth and drained, where the order of the data breaks or the full flag comes early or late by one entry. A missed flush shows as a buffer that is still non-empty in the cycle after a depth-changing write. A guard that leaks shows as a depth of 128 after a write made while the latch bit was clear.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;
  typedef enum logic [2:0] {
    MODE_BYTE  = 3'd0,
    MODE_STD   = 3'd1,
    MODE_DEEP  = 3'd2,
    MODE_ENH   = 3'd3
  } uart_mode_e;

  localparam logic [1:0] ADDR_FIFO_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LINE_CTRL = 2'd1;
  localparam logic [1:0] ADDR_FEAT_CTRL = 2'd2;

  localparam int BIT_FIFO_ON  = 0;
  localparam int BIT_EXTEND   = 5;
  localparam int BIT_LATCH    = 7;
  localparam int BIT_ENHANCED = 4;
endpackage

// File: rtl/uart_mode_regs.sv
module uart_mode_regs
  import uart_mode_pkg::*;
#(
  parameter int STD_DEPTH = 16,
  parameter int EXT_DEPTH = 128,
  localparam int CNT_W = $clog2(EXT_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output uart_mode_e       mode,
  output logic [CNT_W-1:0] depth,
  output logic             auto_flow_en,
  output logic             sleep_en,
  output logic             flush
);
  logic fifo_on_q, extend_q, latch_q, enh_q;
  logic fifo_on_d, extend_d, latch_d, enh_d;

  function automatic logic [CNT_W-1:0] pick_depth(logic on, logic ext, logic enh);
    if (!on)            return CNT_W'(1);
    else if (enh || ext) return CNT_W'(EXT_DEPTH);
    else                return CNT_W'(STD_DEPTH);
  endfunction

  always_comb begin
    fifo_on_d = fifo_on_q;
    extend_d  = extend_q;
    latch_d   = latch_q;
    enh_d     = enh_q;
    if (reg_we) begin
      case (reg_addr)
        ADDR_FIFO_CTRL: begin
          fifo_on_d = reg_wdata[BIT_FIFO_ON];
          if (latch_q) extend_d = reg_wdata[BIT_EXTEND];
        end
        ADDR_LINE_CTRL: latch_d = reg_wdata[BIT_LATCH];
        ADDR_FEAT_CTRL: enh_d   = reg_wdata[BIT_ENHANCED];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_on_q <= 1'b0;
      extend_q  <= 1'b0;
      latch_q   <= 1'b0;
      enh_q     <= 1'b0;
    end else begin
      fifo_on_q <= fifo_on_d;
      extend_q  <= extend_d;
      latch_q   <= latch_d;
      enh_q     <= enh_d;
    end
  end

  assign depth = pick_depth(fifo_on_q, extend_q, enh_q);
  assign flush = pick_depth(fifo_on_d, extend_d, enh_d) != depth;

  always_comb begin
    if (!fifo_on_q)    mode = MODE_BYTE;
    else if (enh_q)    mode = MODE_ENH;
    else if (extend_q) mode = MODE_DEEP;
    else               mode = MODE_STD;
  end

  assign auto_flow_en = fifo_on_q && extend_q && !enh_q;
  assign sleep_en     = fifo_on_q && extend_q && !enh_q;

  assert_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_FIFO_CTRL && !latch_q) |=> $stable(extend_q));

  assert_byte_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BYTE) |-> (depth == CNT_W'(1)));
endmodule

// File: rtl/uart_mode_fifo.sv
module uart_mode_fifo #(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 128,
  localparam int PTR_W = $clog2(MAX_DEPTH),
  localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [CNT_W-1:0]  depth,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              full,
  output logic              empty,
  output logic              overrun
);
  logic [DATA_W-1:0] mem [MAX_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              push, pop;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p, logic [CNT_W-1:0] lim);
    if (CNT_W'(p) + CNT_W'(1) >= lim) return '0;
    else return p + PTR_W'(1);
  endfunction

  assign full      = count >= depth;
  assign empty     = count == '0;
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready && !flush;
  assign pop       = out_valid && out_ready && !flush;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= in_valid && !in_ready && !flush;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        count  <= '0;
      end else begin
        if (push) wr_ptr <= bump(wr_ptr, depth);
        if (pop)  rd_ptr <= bump(rd_ptr, depth);
        case ({push, pop})
          2'b10:   count <= count + CNT_W'(1);
          2'b01:   count <= count - CNT_W'(1);
          default: ;
        endcase
      end
    end
  end

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= depth);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(in_valid && full));

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  assert_not_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
endmodule

// File: rtl/uart_fifo_mode_ctrl.sv
module uart_fifo_mode_ctrl
  import uart_mode_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STD_DEPTH = 16,
  parameter int EXT_DEPTH = 128,
  localparam int CNT_W = $clog2(EXT_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [2:0]        mode,
  output logic [CNT_W-1:0]  depth,
  output logic              auto_flow_en,
  output logic              sleep_en,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_overrun,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [DATA_W-1:0] rx_out_data,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_overrun
);
  uart_mode_e mode_e;
  logic       flush;

  uart_mode_regs #(.STD_DEPTH(STD_DEPTH), .EXT_DEPTH(EXT_DEPTH)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
    .mode(mode_e), .depth, .auto_flow_en, .sleep_en, .flush
  );

  assign mode = mode_e;

  uart_mode_fifo #(.DATA_W(DATA_W), .MAX_DEPTH(EXT_DEPTH)) u_tx (
    .clk, .rst_n, .flush, .depth,
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .full(tx_full), .empty(tx_empty), .overrun(tx_overrun)
  );

  uart_mode_fifo #(.DATA_W(DATA_W), .MAX_DEPTH(EXT_DEPTH)) u_rx (
    .clk, .rst_n, .flush, .depth,
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .full(rx_full), .empty(rx_empty), .overrun(rx_overrun)
  );

  assert_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_flow_en || sleep_en) |-> (mode == 3'd2));

  assert_enh_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> (depth == CNT_W'(EXT_DEPTH)));
endmodule

// File: tb/uart_fifo_mode_ctrl_test.sv
module uart_fifo_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [2:0] mode;
  logic [7:0] depth;
  logic       auto_flow_en, sleep_en;
  logic       tx_in_valid = 1'b0, tx_in_ready, tx_out_valid, tx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0, tx_out_data;
  logic       tx_full, tx_empty, tx_overrun;
  logic       rx_in_valid = 1'b0, rx_in_ready, rx_out_valid, rx_out_ready = 1'b0;
  logic [7:0] rx_in_data = '0, rx_out_data;
  logic       rx_full, rx_empty, rx_overrun;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_mode_ctrl uut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
    .mode, .depth, .auto_flow_en, .sleep_en,
    .tx_in_valid, .tx_in_ready, .tx_in_data, .tx_out_valid, .tx_out_ready,
    .tx_out_data, .tx_full, .tx_empty, .tx_overrun,
    .rx_in_valid, .rx_in_ready, .rx_in_data, .rx_out_valid, .rx_out_ready,
    .rx_out_data, .rx_full, .rx_empty, .rx_overrun
  );

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push(bit rx, logic [7:0] d);
    @(negedge clk);
    if (rx) begin rx_in_valid = 1'b1; rx_in_data = d; end
    else    begin tx_in_valid = 1'b1; tx_in_data = d; end
    @(negedge clk);
    rx_in_valid = 1'b0; tx_in_valid = 1'b0;
  endtask

  task automatic pop_chk(bit rx, logic [7:0] exp, string req);
    @(negedge clk);
    if (rx) begin
      chk(req, "rx valid", rx_out_valid, 1);
      chk(req, "rx data", rx_out_data, exp);
      rx_out_ready = 1'b1;
    end else begin
      chk(req, "tx valid", tx_out_valid, 1);
      chk(req, "tx data", tx_out_data, exp);
      tx_out_ready = 1'b1;
    end
    @(negedge clk);
    rx_out_ready = 1'b0; tx_out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "mode", mode, 0);
    chk("R1", "depth", depth, 1);
    chk("R1", "tx empty", tx_empty, 1);
    chk("R1", "rx empty", rx_empty, 1);
    chk("R1", "tx ready", tx_in_ready, 1);
    chk("R1", "flow en", auto_flow_en, 0);
    chk("R1", "sleep en", sleep_en, 0);
  endtask

  task automatic t_byte_mode();
    push(0, 8'hA5);
    chk("R9", "byte full", tx_full, 1);
    chk("R8", "byte ready low", tx_in_ready, 0);
    @(negedge clk);
    tx_in_valid = 1'b1; tx_in_data = 8'h11;
    @(negedge clk);
    tx_in_valid = 1'b0;
    chk("R9", "overrun pulse", tx_overrun, 1);
    @(negedge clk);
    chk("R9", "overrun ends", tx_overrun, 0);
    pop_chk(0, 8'hA5, "R9");
    chk("R8", "empty after pop", tx_empty, 1);
    // extension and enhanced bits set while buffers disabled
    wr(1, 8'h80);
    wr(0, 8'h20);
    wr(2, 8'h10);
    chk("R2", "depth off", depth, 1);
    chk("R2", "mode off", mode, 0);
    wr(2, 8'h00);
    wr(0, 8'h00);
    wr(1, 8'h00);
  endtask

  task automatic t_std_mode();
    wr(0, 8'h01);
    chk("R3", "mode", mode, 1);
    chk("R3", "depth", depth, 16);
    for (int i = 0; i < 16; i++) push(0, 8'(i + 8'h40));
    chk("R9", "full at 16", tx_full, 1);
    @(negedge clk);
    tx_in_valid = 1'b1; tx_in_data = 8'hEE;
    @(negedge clk);
    tx_in_valid = 1'b0;
    chk("R9", "overrun at 16", tx_overrun, 1);
    for (int i = 0; i < 16; i++) pop_chk(0, 8'(i + 8'h40), "R8");
    chk("R9", "dropped beat absent", tx_empty, 1);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 10; i++) push(1, 8'(i));
    for (int i = 0; i < 10; i++) pop_chk(1, 8'(i), "R11");
    for (int i = 0; i < 16; i++) push(1, 8'(i + 8'h80));
    chk("R11", "full after wrap", rx_full, 1);
    for (int i = 0; i < 16; i++) pop_chk(1, 8'(i + 8'h80), "R11");
  endtask

  task automatic t_guard();
    wr(0, 8'h21);
    chk("R5", "guarded depth", depth, 16);
    chk("R5", "guarded mode", mode, 1);
    wr(1, 8'h80);
    wr(0, 8'h21);
    chk("R4", "deep mode", mode, 2);
    chk("R4", "deep depth", depth, 128);
    chk("R7", "flow on", auto_flow_en, 1);
    chk("R7", "sleep on", sleep_en, 1);
    wr(1, 8'h00);
    wr(0, 8'h01);
    chk("R5", "bit kept", depth, 128);
    for (int i = 0; i < 128; i++) push(0, 8'(i));
    chk("R4", "full at 128", tx_full, 1);
    chk("R8", "ready low at 128", tx_in_ready, 0);
    for (int i = 0; i < 128; i++) pop_chk(0, 8'(i), "R4");
  endtask

  task automatic t_enhanced();
    push(0, 8'h31); push(0, 8'h32); push(0, 8'h33);
    wr(2, 8'h10);
    chk("R6", "enh mode", mode, 3);
    chk("R6", "enh depth", depth, 128);
    chk("R7", "flow off enh", auto_flow_en, 0);
    chk("R7", "sleep off enh", sleep_en, 0);
    chk("R10", "kept on same depth", tx_empty, 0);
    pop_chk(0, 8'h31, "R10");
    // enhanced with extension cleared still 128
    wr(1, 8'h80);
    wr(0, 8'h01);
    wr(1, 8'h00);
    chk("R6", "enh ignores ext", depth, 128);
    push(1, 8'h55);
    wr(2, 8'h00);
    chk("R10", "depth now 16", depth, 16);
    chk("R10", "tx flushed", tx_empty, 1);
    chk("R10", "rx flushed", rx_empty, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_mode();
    t_std_mode();
    t_wrap();
    t_guard();
    t_enhanced();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule